// File: doc/BRIEF.md
# Clock Lane Receive Sequencer

This block sequences the receive side of a serial clock lane. It watches the decoded low-power line state and treats the stop state (LP-11) as rest and the bridge state (LP-00) as the start of high-speed entry. From the reference clock edge that first samples the bridge state, two programmable delays run side by side. The first delay gates the line termination. The second is a settle window during which the clock transition strobe from the analog front end is not trusted.

Once the settle window has expired, the first trusted transition raises a clock-valid flag. From then on a watchdog counts reference cycles with no transition. When the gap reaches a programmed length, the block turns off the high-speed receiver, drops clock-valid and latches an error flag. That flag stays set until software clears it. A return to the stop state cancels any sequence in progress. All delays are counted in reference clock cycles and are loaded when the bridge state is detected.

Top module: `clk_lane_rx_seq`

## Requirements
- R1: While idle, sampling lp_state = 2'b00 (bridge) raises hs_rx_en on that edge. The codes 2'b01 and 2'b10 start nothing. 2'b11 is the stop state.
- R2: term_en rises on the T-th clock edge after the detecting edge, where T = term_dly. When T = 0 it rises on the detecting edge itself, and it stays high until the stop state.
- R3: Strobes on clk_edge sampled on any edge up to and including the S-th edge after detection (S = settle_len) are ignored. They do not raise clk_valid and they do not feed the watchdog.
- R4: clk_valid rises on the first edge after the settle window that samples clk_edge high while hs_rx_en is high, and clk_valid is never high without hs_rx_en.
- R5: After settle, M consecutive edges without a strobe (M = miss_len) drop hs_rx_en and clk_valid on the M-th such edge. Any strobe restarts the count, and M = 0 turns the watchdog off.
- R6: Sampling the stop state clears term_en, hs_rx_en and clk_valid on that edge and resets every timer. A later bridge state starts a fresh sequence with the delays measured from the new detection.
- R7: miss_err is set by a timeout and is cleared by err_clr on an edge without a timeout. It is not cleared by the stop state.
- R8: After detection, neither repeated bridge states nor strobes restart the sequence or revive a timed-out receiver until the stop state has been seen.
- R9: After reset all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_state | input | 2 | Decoded low-power line state, {P,N} |
| clk_edge | input | 1 | One-cycle strobe per observed clock transition |
| term_dly | input | TW | Termination delay in cycles |
| settle_len | input | TW | Settle window in cycles |
| miss_len | input | TW | Missing-clock limit in cycles, 0 = off |
| err_clr | input | 1 | Clears miss_err |
| term_en | output | 1 | Line termination enable |
| hs_rx_en | output | 1 | High-speed receiver enable |
| clk_valid | output | 1 | Clock detected and trusted |
| miss_err | output | 1 | Sticky missing-clock error |

## Verification
The assertions check on every cycle the invariants that do not depend on a delay value. These are: the stop state always empties the outputs, clk_valid never appears without the receiver enabled, and every rise of clk_valid follows a sampled strobe after settle. They also check that a timeout always removes the receiver and leaves the error set, that the error persists until cleared, and that a started sequence does not reset itself. The exact edge on which termination appears, the edge on which early strobes stop being ignored, and the precise gap length that trips the watchdog depend on the programmed counts. Only the directed scenarios show these, because they sample the outputs on the predicted edges.

// File: rtl/clk_lane_rx_pkg.sv
package clk_lane_rx_pkg;
  typedef enum logic [1:0] {
    LP_BRIDGE = 2'b00,
    LP_LOW_P  = 2'b01,
    LP_LOW_N  = 2'b10,
    LP_STOP   = 2'b11
  } lp_code_e;
endpackage

// File: rtl/clk_lane_dly_timer.sv
module clk_lane_dly_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      done <= (load_val == '0);
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) done <= 1'b1;
    end
  end

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !clear && !load) |=> done); // R2
endmodule

// File: rtl/clk_lane_miss_wdog.sv
module clk_lane_miss_wdog #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          mon_en,
  input  logic          clk_edge,
  input  logic [TW-1:0] miss_len,
  output logic          timeout
);
  localparam logic [TW-1:0] ONE = TW'(1);
  localparam logic [TW-1:0] TOP = '1;

  logic [TW-1:0] gap_cnt;
  logic [TW-1:0] gap_nxt;

  always_comb begin
    gap_nxt = gap_cnt + ONE;
    timeout = mon_en && !clk_edge && (miss_len != '0) && (gap_nxt == miss_len);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      gap_cnt <= '0;
    end else if (mon_en) begin
      if (clk_edge || timeout) gap_cnt <= '0;
      else if (gap_cnt != TOP) gap_cnt <= gap_nxt;
    end
  end

  AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (mon_en && clk_edge && !clear) |=> (gap_cnt == '0)); // R5
endmodule

// File: rtl/clk_lane_rx_seq.sv
module clk_lane_rx_seq #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    lp_state,
  input  logic          clk_edge,
  input  logic [TW-1:0] term_dly,
  input  logic [TW-1:0] settle_len,
  input  logic [TW-1:0] miss_len,
  input  logic          err_clr,
  output logic          term_en,
  output logic          hs_rx_en,
  output logic          clk_valid,
  output logic          miss_err
);
  import clk_lane_rx_pkg::*;

  logic active;
  logic at_stop;
  logic entry;
  logic settle_done;
  logic mon_en;
  logic timeout;
  logic restart;

  always_comb begin
    at_stop = (lp_code_e'(lp_state) == LP_STOP);
    entry   = !active && (lp_code_e'(lp_state) == LP_BRIDGE);
    mon_en  = active && settle_done && hs_rx_en;
    restart = at_stop || entry;
  end

  clk_lane_dly_timer #(.TW(TW)) u_term_tmr (
    .clk(clk), .rst(rst), .clear(at_stop), .load(entry),
    .load_val(term_dly), .done(term_en)
  );

  clk_lane_dly_timer #(.TW(TW)) u_settle_tmr (
    .clk(clk), .rst(rst), .clear(at_stop), .load(entry),
    .load_val(settle_len), .done(settle_done)
  );

  clk_lane_miss_wdog #(.TW(TW)) u_wdog (
    .clk(clk), .rst(rst), .clear(restart), .mon_en(mon_en),
    .clk_edge(clk_edge), .miss_len(miss_len), .timeout(timeout)
  );

  always_ff @(posedge clk) begin
    if (rst || at_stop) begin
      active    <= 1'b0;
      hs_rx_en  <= 1'b0;
      clk_valid <= 1'b0;
    end else if (entry) begin
      active    <= 1'b1;
      hs_rx_en  <= 1'b1;
      clk_valid <= 1'b0;
    end else if (timeout) begin
      hs_rx_en  <= 1'b0;
      clk_valid <= 1'b0;
    end else if (mon_en && clk_edge) begin
      clk_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           miss_err <= 1'b0;
    else if (timeout)  miss_err <= 1'b1;
    else if (err_clr)  miss_err <= 1'b0;
  end

  AST_STOP_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    at_stop |=> (!term_en && !hs_rx_en && !clk_valid)); // R6
  AST_VALID_NEEDS_RX: assert property (@(posedge clk) disable iff (rst)
    clk_valid |-> hs_rx_en); // R4
  AST_VALID_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_valid) |-> ($past(clk_edge) && $past(settle_done))); // R3
  AST_TIMEOUT_DROPS_RX: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (!hs_rx_en && !clk_valid && miss_err)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (miss_err && !err_clr) |=> miss_err); // R7
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
    (active && !at_stop) |=> active); // R8
  AST_TERM_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
    $rose(term_en) |-> active); // R2
endmodule

// File: tb/clk_lane_rx_seq_test.sv
module clk_lane_rx_seq_test;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] lp_state = 2'b11;
  logic clk_edge = 1'b0;
  logic [TW-1:0] term_dly = '0;
  logic [TW-1:0] settle_len = '0;
  logic [TW-1:0] miss_len = '0;
  logic err_clr = 1'b0;
  logic term_en, hs_rx_en, clk_valid, miss_err;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  clk_lane_rx_seq #(.TW(TW)) uut (
    .clk(clk), .rst(rst), .lp_state(lp_state), .clk_edge(clk_edge),
    .term_dly(term_dly), .settle_len(settle_len), .miss_len(miss_len),
    .err_clr(err_clr), .term_en(term_en), .hs_rx_en(hs_rx_en),
    .clk_valid(clk_valid), .miss_err(miss_err)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic go_stop();
    lp_state = 2'b11; clk_edge = 1'b0;
    step(2);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(2);
    chk("R9", "term_en", term_en, 1'b0);
    chk("R9", "hs_rx_en", hs_rx_en, 1'b0);
    chk("R9", "clk_valid", clk_valid, 1'b0);
    chk("R9", "miss_err", miss_err, 1'b0);
    rst = 1'b0; step(1);
  endtask

  task automatic t_full_seq();
    term_dly = 8'd3; settle_len = 8'd6; miss_len = 8'd4;
    go_stop();
    lp_state = 2'b01; step(2);
    chk("R1", "hs_rx_en after 01", hs_rx_en, 1'b0);
    lp_state = 2'b00; step(1);                   // detecting edge E0
    chk("R1", "hs_rx_en at E0", hs_rx_en, 1'b1);
    chk("R2", "term_en at E0", term_en, 1'b0);
    step(2);                                      // E2
    chk("R2", "term_en at E2", term_en, 1'b0);
    step(1);                                      // E3
    chk("R2", "term_en at E3", term_en, 1'b1);
    clk_edge = 1'b1; step(3);                     // E4..E6 strobes inside settle
    chk("R3", "clk_valid at E6", clk_valid, 1'b0);
    step(1);                                      // E7 first trusted strobe
    chk("R4", "clk_valid at E7", clk_valid, 1'b1);
    for (int k = 0; k < 5; k++) begin
      clk_edge = 1'b0; step(3);
      clk_edge = 1'b1; step(1);
    end
    chk("R5", "hs_rx_en with gaps below limit", hs_rx_en, 1'b1);
    clk_edge = 1'b0; step(3);
    chk("R5", "hs_rx_en after 3 idle", hs_rx_en, 1'b1);
    step(1);
    chk("R5", "hs_rx_en after 4 idle", hs_rx_en, 1'b0);
    chk("R5", "clk_valid after timeout", clk_valid, 1'b0);
    chk("R7", "miss_err set", miss_err, 1'b1);
    chk("R2", "term_en kept after timeout", term_en, 1'b1);
    clk_edge = 1'b1; step(3);
    chk("R8", "hs_rx_en not revived", hs_rx_en, 1'b0);
    chk("R8", "clk_valid not revived", clk_valid, 1'b0);
    lp_state = 2'b11; clk_edge = 1'b0; step(1);
    chk("R6", "term_en at stop", term_en, 1'b0);
    chk("R7", "miss_err survives stop", miss_err, 1'b1);
    err_clr = 1'b1; step(1); err_clr = 1'b0;
    chk("R7", "miss_err cleared", miss_err, 1'b0);
  endtask

  task automatic t_zero_term();
    term_dly = 8'd0; settle_len = 8'd2; miss_len = 8'd0;
    go_stop();
    lp_state = 2'b00; step(1);
    chk("R2", "term_en at E0 with T=0", term_en, 1'b1);
    step(20);
    chk("R5", "watchdog off keeps rx", hs_rx_en, 1'b1);
    chk("R4", "clk_valid without strobe", clk_valid, 1'b0);
    clk_edge = 1'b1; step(1); clk_edge = 1'b0;
    chk("R4", "clk_valid after strobe", clk_valid, 1'b1);
    lp_state = 2'b10; step(2);
    chk("R8", "10 code keeps sequence", clk_valid, 1'b1);
  endtask

  task automatic t_abort();
    term_dly = 8'd5; settle_len = 8'd8; miss_len = 8'd3;
    go_stop();
    lp_state = 2'b00; step(3);
    lp_state = 2'b11; step(1);
    chk("R6", "hs_rx_en at stop", hs_rx_en, 1'b0);
    lp_state = 2'b00; step(1);                   // new E0
    chk("R6", "hs_rx_en re-entry", hs_rx_en, 1'b1);
    step(4);
    chk("R6", "term_en at new E4", term_en, 1'b0);
    step(1);
    chk("R6", "term_en at new E5", term_en, 1'b1);
    clk_edge = 1'b1; step(3);                     // E6..E8 in settle
    chk("R3", "clk_valid at new E8", clk_valid, 1'b0);
    chk("R8", "rx on during settle", hs_rx_en, 1'b1);
    step(1); clk_edge = 1'b0;
    chk("R4", "clk_valid at new E9", clk_valid, 1'b1);
    go_stop();
  endtask

  initial begin
    t_reset();
    t_full_seq();
    t_zero_term();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule